// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Unit

This unit watches twenty-three general-purpose input pins and raises an interrupt request when any selected pin changes level. The pins are split into three groups: pins 7..0 form group 0, pins 14..8 form group 1, and pins 23..16 form group 2. Index 15 has no pin behind it. Each group owns a mask byte that selects which of its pins may take part. Each group also has a bit in a control byte that enables it, and one shared flag that records that some selected pin in the group toggled. Individual pins are never flagged on their own.

Every pin passes through a synchronizer. Its synchronized level is then compared with the level one cycle earlier, so a change in either direction counts. A group flag drives one request line toward the interrupt arbiter, qualified by the group enable and by a global enable input. The arbiter returns a per-group acknowledge that clears the flag. Software can also clear a flag by writing a one to it through the register port. Writes are captured on the rising clock edge. Reads are combinational from the address.

Top module: `pcx_unit`

## Requirements
- R1: After reset all group enables, flags and mask bits are zero, every request line is low, and every register address reads 0x00.
- R2: Pins 7..0 belong to group 0, pins 14..8 to group 1 and pins 23..16 to group 2. Mask bit k of group g's mask byte selects pin 8*g+k. Pin input 15 never affects any flag.
- R3: A change in either direction on a selected pin of an enabled group sets that group's flag. The pin is driven away from the clock edge before rising edge 1. The flag is still clear after rising edge 2 and is set after rising edge 3.
- R4: A pin whose mask bit is zero is ignored even when its group is enabled. Toggles on deselected pins in the same cycle as a selected toggle change nothing about the outcome.
- R5: While a group's enable bit is zero, toggles on its selected pins do not set its flag.
- R6: Request line irq_o[g] is high exactly when flag g, group enable g and the global enable are all one. Dropping either enable lowers the request but keeps the flag.
- R7: A one on ack_i[g] clears flag g at the next rising edge.
- R8: Writing the flag register clears each flag whose write-data bit is one and leaves flags whose bit is zero unchanged.
- R9: When a set event and a clear (acknowledge or write-one) meet at the same edge, the flag ends up set.
- R10: Register map: address 0 holds the group enables in bits 2..0, address 1 the flags in bits 2..0, and addresses 2, 3 and 4 the mask bytes of groups 0, 1 and 2. Unused bits and addresses 5..7 read zero. Bit 7 of the group 1 mask byte is not stored and reads zero.
- R11: A register write with wr_en_i high is visible on rdata_o in the cycle after the rising edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global interrupt enable gating all requests |
| pins_i | input | 24 | Pin levels; bit 15 has no pin |
| ack_i | input | 3 | Per-group acknowledge from the arbiter |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| irq_o | output | 3 | Per-group request toward the arbiter |

## Verification
On every cycle the assertions check several rules. A flag only rises after a qualified set event. A clear without a competing set drops the flag one edge later. A set always wins over a clear. A toggle is reported only when the synchronized level really moved. A control write lands unchanged. The group 1 mask never shows its top bit. Only the bench scenarios can show the rest. They sweep every pin index, both edge directions and both mask settings, which gives the group mapping, the missing pin 15 and the exact three-edge latency. They also place clears and set events in the same cycle, and show that the enables qualify requests without erasing flags.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int GROUPS = 3;
  localparam int SLOT_W = 8;
  localparam int PIN_W  = GROUPS * SLOT_W;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_FLAG = 3'd1,
    A_MSK0 = 3'd2,
    A_MSK1 = 3'd3,
    A_MSK2 = 3'd4
  } reg_addr_e;

  // Bits of a group's slot that have a pin behind them (group 1 lacks its top slot).
  function automatic logic [SLOT_W-1:0] slot_valid(input int g);
    return (g == 1) ? {1'b0, {(SLOT_W-1){1'b1}}} : {SLOT_W{1'b1}};
  endfunction

  function automatic logic [ADDR_W-1:0] mask_addr(input int g);
    return ADDR_W'(int'(A_MSK0) + g);
  endfunction
endpackage

// File: rtl/pcx_sync.sv
module pcx_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] toggle_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;
  logic [W-1:0] sync_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= din_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_w   = stg_q[STAGES-1];
  assign toggle_o = sync_w ^ prev_q;

  // R3
  toggle_real_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|toggle_o) |-> (sync_w != $past(sync_w)));
endmodule

// File: rtl/pcx_grp_flag.sv
module pcx_grp_flag
  import pcx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] tgl_i,
  input  logic [SLOT_W-1:0] mask_i,
  input  logic              grp_en_i,
  input  logic              ack_i,
  input  logic              w1c_i,
  output logic              flag_o
);
  logic [SLOT_W-1:0] hit_w;
  logic              set_ev;
  logic              clr_ev;
  logic              flag_q;

  assign hit_w  = tgl_i & mask_i;
  assign set_ev = grp_en_i & (|hit_w);
  assign clr_ev = ack_i | w1c_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_ev) flag_q <= 1'b1;
    else if (clr_ev) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R5
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(grp_en_i && (|(tgl_i & mask_i))));
  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_ev && (ack_i || w1c_i)) |=> !flag_q);
  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev |=> flag_q);
endmodule

// File: rtl/pcx_regs.sv
module pcx_regs
  import pcx_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [SLOT_W-1:0]             wdata_i,
  input  logic [GROUPS-1:0]             flags_i,
  output logic [GROUPS-1:0]             ctrl_o,
  output logic [GROUPS-1:0]             w1c_o,
  output logic [GROUPS-1:0][SLOT_W-1:0] mask_o,
  output logic [SLOT_W-1:0]             rdata_o
);
  logic [GROUPS-1:0]             ctrl_q;
  logic [GROUPS-1:0][SLOT_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) ctrl_q <= wdata_i[GROUPS-1:0];
      for (int g = 0; g < GROUPS; g++)
        if (addr_i == mask_addr(g)) mask_q[g] <= wdata_i & slot_valid(g);
    end
  end

  assign w1c_o = (wr_en_i && addr_i == A_FLAG) ? wdata_i[GROUPS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) rdata_o[GROUPS-1:0] = ctrl_q;
    if (addr_i == A_FLAG) rdata_o[GROUPS-1:0] = flags_i;
    for (int g = 0; g < GROUPS; g++)
      if (addr_i == mask_addr(g)) rdata_o = mask_q[g];
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;

  // R10
  msk1_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_MSK1) |-> !rdata_o[SLOT_W-1]);
  // R11
  ctrl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CTRL) |=> (ctrl_q == $past(wdata_i[GROUPS-1:0])));
endmodule

// File: rtl/pcx_unit.sv
module pcx_unit
  import pcx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_en_i,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic [GROUPS-1:0] ack_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SLOT_W-1:0] wdata_i,
  output logic [SLOT_W-1:0] rdata_o,
  output logic [GROUPS-1:0] irq_o
);
  logic [PIN_W-1:0]              tgl_w;
  logic [GROUPS-1:0]             flag_w;
  logic [GROUPS-1:0]             ctrl_w;
  logic [GROUPS-1:0]             w1c_w;
  logic [GROUPS-1:0][SLOT_W-1:0] mask_w;

  pcx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (pins_i),
    .toggle_o(tgl_w)
  );

  pcx_regs regs_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .flags_i(flag_w),
    .ctrl_o (ctrl_w),
    .w1c_o  (w1c_w),
    .mask_o (mask_w),
    .rdata_o(rdata_o)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    pcx_grp_flag flag_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tgl_i   (tgl_w[g*SLOT_W +: SLOT_W]),
      .mask_i  (mask_w[g]),
      .grp_en_i(ctrl_w[g]),
      .ack_i   (ack_i[g]),
      .w1c_i   (w1c_w[g]),
      .flag_o  (flag_w[g])
    );
    assign irq_o[g] = flag_w[g] & ctrl_w[g] & glb_en_i;
  end
endmodule

// File: tb/pcx_unit_tb.sv
module pcx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        glb_en;
  logic [23:0] pins;
  logic [2:0]  ack;
  logic        wr_en;
  logic [2:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [2:0]  irq;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pcx_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .pins_i(pins), .ack_i(ack),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [2:0] exp_flag(input int idx, input bit sel, input bit en);
    if (!sel || !en || idx == 15) return 3'b000;
    return 3'(1 << (idx / 8));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 0; glb_en = 0; pins = '0; ack = '0; wr_en = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 8; a++) begin rd(3'(a), d); chk("R1 read", d, 0); end

    // R10 R11 register map
    for (int a = 0; a < 5; a++) wr(3'(a), 8'hFF);
    rd(0, d); chk("R10 ctrl", d, 8'h07);
    rd(1, d); chk("R10 flag", d, 8'h00);
    rd(2, d); chk("R10 mask0", d, 8'hFF);
    rd(3, d); chk("R10 mask1 bit7 zero", d, 8'h7F);
    rd(4, d); chk("R10 mask2", d, 8'hFF);
    for (int a = 5; a < 8; a++) begin rd(3'(a), d); chk("R10 empty addr", d, 0); end
    wr(2, 8'h5A); rd(2, d); chk("R11 write visible", d, 8'h5A);

    // R2 R3 sweep of every index, both directions, both mask settings
    glb_en = 1;
    wr(0, 8'h07);
    for (int idx = 0; idx < 24; idx++) begin
      for (int m = 0; m < 2; m++) begin
        wr(2, 0); wr(3, 0); wr(4, 0);
        if (m == 1) wr(3'(2 + idx / 8), 8'(1 << (idx % 8)));
        wr(1, 8'h07);
        for (int dir = 0; dir < 2; dir++) begin
          pins[idx] = ~pins[idx];
          repeat (2) @(negedge clk);
          rd(1, d); chk("R3 latency not yet", d, 0);
          @(negedge clk);
          rd(1, d); chk("R2 R3 R4 group flag", d, 8'(exp_flag(idx, m[0], 1'b1)));
          chk("R6 irq follows flag", irq, exp_flag(idx, m[0], 1'b1));
          wr(1, 8'h07);
          rd(1, d); chk("R8 w1c all", d, 0);
        end
      end
    end

    // R5 group disabled
    wr(0, 8'h00); wr(2, 8'hFF);
    pins[3] = ~pins[3];
    repeat (4) @(negedge clk);
    rd(1, d); chk("R5 disabled group no flag", d, 0);

    // R4 deselected toggles ignored, also alongside selected one
    wr(0, 8'h07); wr(2, 8'h01); wr(1, 8'h07);
    pins[7:1] = ~pins[7:1];
    repeat (4) @(negedge clk);
    rd(1, d); chk("R4 deselected pins ignored", d, 0);
    pins[7:0] = ~pins[7:0];
    repeat (3) @(negedge clk);
    rd(1, d); chk("R4 selected plus deselected", d, 8'h01);

    // R7 acknowledge clears
    ack = 3'b001;
    @(negedge clk);
    ack = 3'b000;
    rd(1, d); chk("R7 ack clears", d, 0);

    // R6 enable qualification
    pins[0] = ~pins[0];
    repeat (3) @(negedge clk);
    glb_en = 0; #1;
    chk("R6 global off no irq", irq, 0);
    rd(1, d); chk("R6 flag kept", d, 8'h01);
    glb_en = 1; #1;
    chk("R6 irq on", irq, 3'b001);
    wr(0, 8'h06); #1;
    chk("R6 group off no irq", irq, 0);
    rd(1, d); chk("R6 flag kept group off", d, 8'h01);
    wr(0, 8'h07);

    // R8 write zero keeps, write one clears
    wr(1, 8'h06); rd(1, d); chk("R8 zero bit keeps", d, 8'h01);
    wr(1, 8'h01); rd(1, d); chk("R8 one bit clears", d, 0);

    // R9 set beats acknowledge in same edge
    pins[0] = ~pins[0];
    repeat (2) @(negedge clk);
    ack = 3'b001;
    @(negedge clk);
    ack = 3'b000;
    rd(1, d); chk("R9 set beats ack", d, 8'h01);
    // R9 set beats write-one-clear in same edge
    pins[0] = ~pins[0];
    repeat (2) @(negedge clk);
    wr(1, 8'h01);
    rd(1, d); chk("R9 set beats w1c", d, 8'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule